// File: doc/BRIEF.md
# Runtime-Programmable Parallel CRC Engine

The engine folds a data word of DATA_W bits into a CRC state of up to CRC_MAX bits every clock. The generator polynomial and the CRC width are not fixed when the block is built. Software loads them together with a start value, and then the block works out its own next-state equations. A configuration sequencer runs a combinational model of the bit-serial shift register. It drives that model once for every single-bit data vector and once for every single-bit state vector. Each result is one row of a coefficient matrix. One matrix holds the data rows and the other holds the state rows. There is one probe per clock, so the sequencer takes DATA_W + CRC_MAX clocks.

After that the datapath needs no knowledge of the polynomial. Each next-state bit is the XOR of the data bits and state bits whose stored rows have that bit set. This works because the CRC update is linear. A clear input restores the start value without repeating the derivation, so one configuration can serve many messages. DATA_W can be any value, including values that are not powers of two, such as 11 or 120.

Top module: `crc_prog_engine`

## Requirements
- R1: While reset is held and immediately after its release, crc_out is all ones, cfg_ready is 0 and cfg_busy is 0.
- R2: A cfg_start sampled while cfg_busy is low latches cfg_taps, cfg_init and cfg_width. cfg_busy is then high for exactly DATA_W + CRC_MAX clocks. When it falls, cfg_ready is 1 and crc_out equals cfg_init with every bit at or above the configured width forced to 0.
- R3: A cfg_start pulse, or any change of the configuration inputs, while cfg_busy is high has no effect. The busy time and all later results follow the configuration latched first.
- R4: One clock after an accepted din_valid, crc_out equals DATA_W serial steps applied to the previous crc_out. The steps take din_data[DATA_W-1] first, then go down to din_data[0]. With width W and taps p, one step on state c with bit d computes f = c[W-1] ^ d. It sets new c[0] = f and new c[k] = c[k-1] ^ (p[k] & f) for 1 ≤ k < W. The x^W and x^0 terms are implied; cfg_taps carries p[1..CRC_MAX-1].
- R5: Take DATA_W=4, width 5 and taps for x^5+x^2+1 (p[2]=1 only). If the state starts at 0 and the data has only bit j set, the result for j=0..3 is 5'b00101, 5'b01010, 5'b10100 and 5'b01101. If the data is 0 and the state has only bit j set, the result for j=0..4 is 5'b10000, 5'b00101, 5'b01010, 5'b10100 and 5'b01101. New bit 4 equals state[0] ^ state[3] ^ data[2].
- R6: cfg_width W from 1 to CRC_MAX selects the CRC width, and crc_out bits W and above stay 0 once configured. The value 0, or any value above CRC_MAX, selects CRC_MAX.
- R7: din_clear while cfg_ready is high reloads crc_out with the masked start value one clock later. It does not raise cfg_busy, and it takes priority over din_valid in the same clock.
- R8: A clock with din_valid and din_clear both low leaves crc_out unchanged.
- R9: din_valid and din_clear are ignored while cfg_busy is high and before the first configuration has completed.
- R10: A data width that is not a power of two (DATA_W=11) gives the same result as the serial steps of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_taps | input | CRC_MAX-1 | Polynomial coefficients p[CRC_MAX-1:1] |
| cfg_init | input | CRC_MAX | Start value of the CRC state |
| cfg_width | input | $clog2(CRC_MAX+1) | CRC width W |
| cfg_start | input | 1 | Begin matrix derivation |
| cfg_busy | output | 1 | Derivation in progress |
| cfg_ready | output | 1 | Matrices valid, datapath accepts words |
| din_valid | input | 1 | Fold din_data into the state this clock |
| din_data | input | DATA_W | Data word |
| din_clear | input | 1 | Reload the start value |
| crc_out | output | CRC_MAX | Current CRC state |

## Verification
Every data word, clear or idle clock shows its result on crc_out one clock after the edge that samples it. The bench drives inputs on a falling edge and compares crc_out with a behavioural bit-serial model at the next falling edge, which puts each comparison exactly one register stage after its stimulus. A configuration is due DATA_W + CRC_MAX clocks after the edge that samples cfg_start. The bench counts the falling edges that see cfg_busy high and expects that exact number. During those clocks it checks that crc_out keeps its old value even though words and a second start are presented. Matrix rows are observed through the ports: a zero start value with single-bit data words, or a single-bit start value with a zero word.

// File: rtl/crc_prog_pkg.sv
// Shared definitions for the runtime-programmable CRC engine.
// Assumes: nothing beyond SystemVerilog 2017.
package crc_prog_pkg;

    typedef enum logic {
        SQ_IDLE  = 1'b0,
        SQ_PROBE = 1'b1
    } seq_state_t;

    // Effective CRC width: out-of-range requests fall back to the maximum.
    function automatic int eff_width(input int req, input int max_w);
        return (req < 1 || req > max_w) ? max_w : req;
    endfunction

endpackage

// File: rtl/crc_probe_chain.sv
// Combinational model of DATA_W serial LFSR steps, highest data bit first.
// Assumes: mask has ones in bits [W-1:0]; top_sel is one-hot at bit W-1;
// taps carry p[CRC_MAX-1:1] (x^0 and x^W implied).
module crc_probe_chain #(
    parameter int DATA_W  = 32,
    parameter int CRC_MAX = 32
) (
    input  logic [CRC_MAX-1:0] st_in,
    input  logic [DATA_W-1:0]  dat_in,
    input  logic [CRC_MAX-1:1] taps,
    input  logic [CRC_MAX-1:0] mask,
    input  logic [CRC_MAX-1:0] top_sel,
    output logic [CRC_MAX-1:0] res
);

    // Unrolled serial steps producing one matrix row.
    always_comb begin : p_unroll
        logic [CRC_MAX-1:0] cur;
        logic [CRC_MAX-1:0] nxt;
        logic               fb;
        cur = st_in & mask;
        for (int s = 0; s < DATA_W; s++) begin
            fb     = (^(cur & top_sel)) ^ dat_in[DATA_W-1-s];
            nxt[0] = fb;
            for (int k = 1; k < CRC_MAX; k++) begin
                nxt[k] = cur[k-1] ^ (taps[k] & fb);
            end
            cur = nxt & mask;
        end
        res = cur;
    end

endmodule

// File: rtl/crc_cfg_seq.sv
// Configuration sequencer: latches polynomial, start value and width, then
// probes the serial model with one one-hot vector per clock, writing data
// rows first (DATA_W clocks) and state rows after (CRC_MAX clocks).
// Assumes: cfg_start is sampled only while idle.
module crc_cfg_seq
    import crc_prog_pkg::*;
#(
    parameter  int DATA_W  = 32,
    parameter  int CRC_MAX = 32,
    localparam int WW      = $clog2(CRC_MAX + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [CRC_MAX-1:1]               cfg_taps,
    input  logic [CRC_MAX-1:0]               cfg_init,
    input  logic [WW-1:0]                    cfg_width,
    input  logic                             cfg_start,
    output logic                             busy,
    output logic                             ready,
    output logic                             load_init,
    output logic [CRC_MAX-1:0]               init_q,
    output logic [CRC_MAX-1:0]               mask_q,
    output logic [CRC_MAX-1:0][DATA_W-1:0]   h1col,
    output logic [CRC_MAX-1:0][CRC_MAX-1:0]  h2col
);

    localparam int PROBES = DATA_W + CRC_MAX;
    localparam int IW     = $clog2(PROBES);
    localparam int LAST   = PROBES - 1;

    seq_state_t         st_q;
    logic [IW-1:0]      idx_q;
    logic [CRC_MAX-1:1] taps_q;
    logic [CRC_MAX-1:0] top_q;
    logic [CRC_MAX-1:0] mask_new;
    logic [CRC_MAX-1:0] top_new;
    logic [CRC_MAX-1:0] probe_st;
    logic [DATA_W-1:0]  probe_dat;
    logic [CRC_MAX-1:0] probe_res;

    // Width mask and feedback selector for a new configuration.
    always_comb begin : p_mask
        int w_eff;
        w_eff = eff_width(int'(cfg_width), CRC_MAX);
        for (int k = 0; k < CRC_MAX; k++) begin
            mask_new[k] = (k < w_eff);
        end
        top_new = mask_new ^ (mask_new >> 1);
    end

    // One-hot stimulus for the current probe index.
    always_comb begin : p_probe
        for (int j = 0; j < DATA_W; j++) begin
            probe_dat[j] = (idx_q == IW'(j));
        end
        for (int j = 0; j < CRC_MAX; j++) begin
            probe_st[j] = (idx_q == IW'(DATA_W + j));
        end
    end

    crc_probe_chain #(
        .DATA_W  (DATA_W),
        .CRC_MAX (CRC_MAX)
    ) u_chain (
        .st_in   (probe_st),
        .dat_in  (probe_dat),
        .taps    (taps_q),
        .mask    (mask_q),
        .top_sel (top_q),
        .res     (probe_res)
    );

    assign busy      = (st_q == SQ_PROBE);
    assign load_init = busy && (idx_q == IW'(LAST));

    // Sequencer control and configuration latch.
    always_ff @(posedge clk) begin : p_ctrl
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            idx_q  <= '0;
            ready  <= 1'b0;
            taps_q <= '0;
            init_q <= '0;
            mask_q <= '1;
            top_q  <= {1'b1, {(CRC_MAX-1){1'b0}}};
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (cfg_start) begin
                        st_q   <= SQ_PROBE;
                        idx_q  <= '0;
                        ready  <= 1'b0;
                        taps_q <= cfg_taps;
                        init_q <= cfg_init;
                        mask_q <= mask_new;
                        top_q  <= top_new;
                    end
                end
                default: begin
                    if (idx_q == IW'(LAST)) begin
                        st_q  <= SQ_IDLE;
                        ready <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Matrix storage: one row written per probe clock.
    always_ff @(posedge clk) begin : p_rows
        if (!rst_n) begin
            h1col <= '0;
            h2col <= '0;
        end else if (busy) begin
            for (int i = 0; i < CRC_MAX; i++) begin
                for (int j = 0; j < DATA_W; j++) begin
                    if (idx_q == IW'(j)) h1col[i][j] <= probe_res[i];
                end
                for (int j = 0; j < CRC_MAX; j++) begin
                    if (idx_q == IW'(DATA_W + j)) h2col[i][j] <= probe_res[i];
                end
            end
        end
    end

    // R2: busy persists until the last probe.
    a_r2_busy_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load_init) |=> busy);

    // R2: last probe ends busy and raises ready.
    a_r2_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        load_init |=> (!busy && ready));

    // R2: ready never overlaps busy.
    a_r2_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready);

    // R3: latched configuration frozen while probing.
    a_r3_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(taps_q) && $stable(init_q) && $stable(mask_q)));

endmodule

// File: rtl/crc_xor_dp.sv
// Parallel CRC datapath: each next-state bit is an XOR reduction of the data
// word and current state through the stored coefficient columns.
// Assumes: columns above the configured width are zero.
module crc_xor_dp #(
    parameter int DATA_W  = 32,
    parameter int CRC_MAX = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [CRC_MAX-1:0][DATA_W-1:0]   h1col,
    input  logic [CRC_MAX-1:0][CRC_MAX-1:0]  h2col,
    input  logic [CRC_MAX-1:0]               init_q,
    input  logic [CRC_MAX-1:0]               mask_q,
    input  logic                             load_init,
    input  logic                             busy,
    input  logic                             ready,
    input  logic                             din_valid,
    input  logic [DATA_W-1:0]                din_data,
    input  logic                             din_clear,
    output logic [CRC_MAX-1:0]               state_q
);

    logic [CRC_MAX-1:0] nxt;
    logic               live;

    assign live = ready && !busy;

    // XOR reduction per output bit.
    always_comb begin : p_next
        for (int i = 0; i < CRC_MAX; i++) begin
            nxt[i] = (^(din_data & h1col[i])) ^ (^(state_q & h2col[i]));
        end
    end

    // State register: reset, start-value load, clear, word update.
    always_ff @(posedge clk) begin : p_state
        if (!rst_n) begin
            state_q <= '1;
        end else if (load_init) begin
            state_q <= init_q & mask_q;
        end else if (live && din_clear) begin
            state_q <= init_q & mask_q;
        end else if (live && din_valid) begin
            state_q <= nxt;
        end
    end

    // R8: idle clock holds the state.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!din_valid && !din_clear && !load_init) |=> $stable(state_q));

    // R9: inputs ignored while not ready.
    a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !load_init) |=> $stable(state_q));

    // R6: bits above the width stay zero once configured.
    a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ((state_q & ~mask_q) == '0));

    // R7: clear reloads the start value.
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (live && din_clear) |=> (state_q == $past(init_q & mask_q)));

endmodule

// File: rtl/crc_prog_engine.sv
// Top level of the runtime-programmable parallel CRC engine: joins the
// configuration sequencer and the XOR datapath.
// Assumes: DATA_W >= 1, CRC_MAX >= 2.
module crc_prog_engine #(
    parameter  int DATA_W  = 32,
    parameter  int CRC_MAX = 32,
    localparam int WW      = $clog2(CRC_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CRC_MAX-1:1] cfg_taps,
    input  logic [CRC_MAX-1:0] cfg_init,
    input  logic [WW-1:0]      cfg_width,
    input  logic               cfg_start,
    output logic               cfg_busy,
    output logic               cfg_ready,
    input  logic               din_valid,
    input  logic [DATA_W-1:0]  din_data,
    input  logic               din_clear,
    output logic [CRC_MAX-1:0] crc_out
);

    logic                            load_init;
    logic [CRC_MAX-1:0]              init_q;
    logic [CRC_MAX-1:0]              mask_q;
    logic [CRC_MAX-1:0][DATA_W-1:0]  h1col;
    logic [CRC_MAX-1:0][CRC_MAX-1:0] h2col;

    crc_cfg_seq #(
        .DATA_W  (DATA_W),
        .CRC_MAX (CRC_MAX)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_taps  (cfg_taps),
        .cfg_init  (cfg_init),
        .cfg_width (cfg_width),
        .cfg_start (cfg_start),
        .busy      (cfg_busy),
        .ready     (cfg_ready),
        .load_init (load_init),
        .init_q    (init_q),
        .mask_q    (mask_q),
        .h1col     (h1col),
        .h2col     (h2col)
    );

    crc_xor_dp #(
        .DATA_W  (DATA_W),
        .CRC_MAX (CRC_MAX)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .h1col     (h1col),
        .h2col     (h2col),
        .init_q    (init_q),
        .mask_q    (mask_q),
        .load_init (load_init),
        .busy      (cfg_busy),
        .ready     (cfg_ready),
        .din_valid (din_valid),
        .din_data  (din_data),
        .din_clear (din_clear),
        .state_q   (crc_out)
    );

endmodule

// File: tb/crc_prog_engine_bench.sv
// Self-checking bench: behavioural bit-serial reference, compared every clock.
module crc_prog_engine_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;

    // Main instance: 32-bit words, up to 32-bit CRC.
    logic [31:1] m_taps;
    logic [31:0] m_init;
    logic [5:0]  m_width;
    logic        m_start, m_busy, m_ready, m_valid, m_clear;
    logic [31:0] m_data, m_crc;

    // Small instances: 4-bit and 11-bit words, 5-bit CRC, shared config.
    logic [4:1]  s_taps;
    logic [4:0]  s_init;
    logic [2:0]  s_width;
    logic        s_start, s_valid, s_clear;
    logic [3:0]  s4_data;
    logic [10:0] s11_data;
    logic        s4_busy, s4_ready, s11_busy, s11_ready;
    logic [4:0]  s4_crc, s11_crc;

    crc_prog_engine #(.DATA_W(32), .CRC_MAX(32)) u_crc_prog_engine (
        .clk(clk), .rst_n(rst_n), .cfg_taps(m_taps), .cfg_init(m_init),
        .cfg_width(m_width), .cfg_start(m_start), .cfg_busy(m_busy),
        .cfg_ready(m_ready), .din_valid(m_valid), .din_data(m_data),
        .din_clear(m_clear), .crc_out(m_crc));

    crc_prog_engine #(.DATA_W(4), .CRC_MAX(5)) u_crc_prog_engine_n4 (
        .clk(clk), .rst_n(rst_n), .cfg_taps(s_taps), .cfg_init(s_init),
        .cfg_width(s_width), .cfg_start(s_start), .cfg_busy(s4_busy),
        .cfg_ready(s4_ready), .din_valid(s_valid), .din_data(s4_data),
        .din_clear(s_clear), .crc_out(s4_crc));

    crc_prog_engine #(.DATA_W(11), .CRC_MAX(5)) u_crc_prog_engine_n11 (
        .clk(clk), .rst_n(rst_n), .cfg_taps(s_taps), .cfg_init(s_init),
        .cfg_width(s_width), .cfg_start(s_start), .cfg_busy(s11_busy),
        .cfg_ready(s11_ready), .din_valid(s_valid), .din_data(s11_data),
        .din_clear(s_clear), .crc_out(s11_crc));

    logic [31:0] m_exp, m_poly_e, m_init_e;
    int          m_w_e;
    logic [31:0] s_poly_e;
    logic [4:0]  s4_exp, s11_exp, s_init_e;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] wmask(input int w);
        return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    endfunction

    // Reference: serial LFSR, bits from nb-1 down to 0.
    function automatic logic [31:0] ref_word(input logic [31:0] c, input logic [31:0] d,
                                             input int nb, input logic [31:0] poly, input int w);
        logic [31:0] r;
        logic        fb;
        r = c & wmask(w);
        for (int b = nb - 1; b >= 0; b--) begin
            fb = r[w-1] ^ d[b];
            r  = ((r << 1) ^ (fb ? (poly | 32'h1) : 32'h0)) & wmask(w);
        end
        return r;
    endfunction

    // Configure main instance; pokes words and a second start while busy.
    task automatic m_config(input logic [31:0] poly, input logic [31:0] init, input int wreq);
        int n;
        logic [31:0] held;
        m_taps = poly[31:1]; m_init = init; m_width = 6'(wreq); m_start = 1'b1;
        m_w_e = (wreq < 1 || wreq > 32) ? 32 : wreq;
        m_poly_e = poly; m_init_e = init;
        held = m_crc;
        @(negedge clk);
        m_start = 1'b0;
        n = 0;
        while (m_busy && n < 200) begin
            n++;
            chk("R9 busy hold", m_crc, held);
            m_valid = 1'b1; m_clear = (n == 2); m_data = $urandom;
            if (n == 3) begin
                m_start = 1'b1; m_taps = ~poly[31:1]; m_init = ~init; m_width = 6'd7;
            end else begin
                m_start = 1'b0; m_taps = poly[31:1]; m_init = init; m_width = 6'(wreq);
            end
            @(negedge clk);
        end
        m_valid = 1'b0; m_clear = 1'b0; m_start = 1'b0;
        chk("R2 R3 busy length", 32'(n), 32'd64);
        chk("R2 ready", {31'd0, m_ready}, 32'd1);
        m_exp = init & wmask(m_w_e);
        chk("R2 R6 start value", m_crc, m_exp);
    endtask

    task automatic m_word(input logic [31:0] d);
        m_valid = 1'b1; m_data = d;
        m_exp = ref_word(m_exp, d, 32, m_poly_e, m_w_e);
        @(negedge clk);
        m_valid = 1'b0;
        chk("R4 R6 word", m_crc, m_exp);
    endtask

    task automatic m_idle(input int n);
        for (int i = 0; i < n; i++) begin
            m_data = $urandom;
            @(negedge clk);
            chk("R8 idle hold", m_crc, m_exp);
        end
    endtask

    task automatic m_clear_word();
        m_clear = 1'b1; m_valid = 1'b1; m_data = $urandom;
        @(negedge clk);
        m_clear = 1'b0; m_valid = 1'b0;
        m_exp = m_init_e & wmask(m_w_e);
        chk("R7 clear value", m_crc, m_exp);
        chk("R7 no busy", {31'd0, m_busy}, 32'd0);
    endtask

    task automatic m_run(input logic [31:0] poly, input logic [31:0] init, input int wreq);
        m_config(poly, init, wreq);
        for (int i = 0; i < 12; i++) m_word($urandom);
        m_idle(2);
        m_clear_word();
        for (int i = 0; i < 6; i++) m_word($urandom);
    endtask

    task automatic s_config(input logic [4:0] poly, input logic [4:0] init);
        int n;
        s_taps = poly[4:1]; s_init = init; s_width = 3'd5; s_start = 1'b1;
        s_poly_e = {27'd0, poly}; s_init_e = init;
        @(negedge clk);
        s_start = 1'b0;
        n = 0;
        while ((s4_busy || s11_busy) && n < 100) begin
            n++;
            @(negedge clk);
        end
        s4_exp = init; s11_exp = init;
        chk("R2 small ready", {30'd0, s4_ready, s11_ready}, 32'd3);
        chk("R2 small start n4", {27'd0, s4_crc}, {27'd0, init});
        chk("R2 small start n11", {27'd0, s11_crc}, {27'd0, init});
    endtask

    task automatic s_word(input logic [3:0] d4, input logic [10:0] d11);
        s_valid = 1'b1; s4_data = d4; s11_data = d11;
        s4_exp  = 5'(ref_word({27'd0, s4_exp}, {28'd0, d4}, 4, s_poly_e, 5));
        s11_exp = 5'(ref_word({27'd0, s11_exp}, {21'd0, d11}, 11, s_poly_e, 5));
        @(negedge clk);
        s_valid = 1'b0;
        chk("R4 n4 word", {27'd0, s4_crc}, {27'd0, s4_exp});
        chk("R10 n11 word", {27'd0, s11_crc}, {27'd0, s11_exp});
    endtask

    task automatic s_clr();
        s_clear = 1'b1;
        @(negedge clk);
        s_clear = 1'b0;
        s4_exp = s_init_e; s11_exp = s_init_e;
        chk("R7 small clear", {27'd0, s4_crc}, {27'd0, s_init_e});
    endtask

    initial begin : p_watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : p_main
        logic [4:0] h1_rows [4];
        logic [4:0] h2_rows [5];
        h1_rows = '{5'b00101, 5'b01010, 5'b10100, 5'b01101};
        h2_rows = '{5'b10000, 5'b00101, 5'b01010, 5'b10100, 5'b01101};
        m_taps = '0; m_init = '0; m_width = '0; m_start = 0; m_valid = 0; m_clear = 0; m_data = '0;
        s_taps = '0; s_init = '0; s_width = '0; s_start = 0; s_valid = 0; s_clear = 0;
        s4_data = '0; s11_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset crc", m_crc, 32'hFFFF_FFFF);
        chk("R1 reset flags", {30'd0, m_ready, m_busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", m_crc, 32'hFFFF_FFFF);
        chk("R1 small after release", {27'd0, s4_crc}, 32'h1F);
        // R9: words before any configuration are ignored.
        m_valid = 1'b1; m_clear = 1'b1; m_data = 32'h1234_5678;
        @(negedge clk);
        m_valid = 1'b0; m_clear = 1'b0;
        chk("R9 unconfigured", m_crc, 32'hFFFF_FFFF);
        chk("R9 unconfigured ready", {31'd0, m_ready}, 32'd0);

        m_run(32'h04C1_1DB7, 32'hFFFF_FFFF, 32);
        m_run(32'h0000_1021, 32'hABCD_FFFF, 16);
        m_run(32'h0000_0005, 32'h0000_001F, 5);
        m_run($urandom | 32'h1, $urandom, 0);
        m_run($urandom | 32'h1, $urandom, 40);
        m_run($urandom | 32'h1, $urandom, int'($urandom_range(2, 31)));
        m_run($urandom | 32'h1, $urandom, 1);

        // R5: data rows via zero start value and one-hot words.
        s_config(5'h05, 5'h00);
        for (int j = 0; j < 4; j++) begin
            s_clr();
            s_word(4'(1 << j), 11'd0);
            chk("R5 data row", {27'd0, s4_crc}, {27'd0, h1_rows[j]});
        end
        // R5: state rows via one-hot start value and zero word.
        for (int j = 0; j < 5; j++) begin
            s_config(5'h05, 5'(1 << j));
            s_word(4'd0, 11'd0);
            chk("R5 state row", {27'd0, s4_crc}, {27'd0, h2_rows[j]});
        end
        // R5: bit 4 equation with state bits 0,3 and data bit 2 set.
        s_config(5'h05, 5'b01001);
        s_word(4'b0100, 11'h5A3);
        chk("R5 bit4 equation", {31'd0, s4_crc[4]}, 32'd1);
        // R10: 11-bit words and random taps.
        s_config(5'h05, 5'h1F);
        for (int i = 0; i < 10; i++) s_word(4'($urandom), 11'($urandom));
        s_config(5'($urandom) | 5'h1, 5'($urandom));
        for (int i = 0; i < 10; i++) s_word(4'($urandom), 11'($urandom));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule